// File: doc/BRIEF.md
# Wildcard Time Alarm Comparator

This block decides, once per second, whether the clock's current time has reached a programmed alarm time. It is given the current seconds, minutes and hours bytes and three alarm bytes, plus the mode bits that set how those bytes are coded. On every update-ended strobe it compares each current field against its alarm field. When all three agree it raises a one-cycle alarm pulse.

Any alarm byte whose two top bits are both set acts as a wildcard and matches any current value. This allows alarms every second, every minute or every hour. Values may be coded as packed BCD or as plain binary. Hours may be in 24-hour form, or in 12-hour form with a PM flag in the top bit. Both the current hour and the alarm hour are brought to a common 0..23 value before they are compared.

The time bytes presented with the strobe are the already-incremented values of that update cycle. While the time is frozen for setting, or while the divider chain is held in reset, no alarm is produced.

Top module: `rtc_alarm_match`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `alarm_pulse` is 0.
- R2: `alarm_pulse` is 1 only in the cycle directly after a cycle with `upd_stb` high, and lasts exactly that one cycle per strobe. With `upd_stb` low, the following cycle shows 0 even if every field matches.
- R3: An alarm byte with bits 7:6 equal to 2'b11 (for example 0xC0 or 0xFF) matches any current value of its field.
- R4: When all three alarm bytes are wildcards, every qualifying strobe produces a pulse, whatever the current time.
- R5: With `bin_mode` = 0, bytes are packed BCD: tens digit in bits 7:4, units digit in bits 3:0.
- R6: With `bin_mode` = 1, bytes are plain binary. For example, a current 0x2D (45) does not match an alarm of 0x45.
- R7: With `h24_mode` = 0, bit 7 of an hour byte is PM and bits 6:0 hold 1..12. The compared hour is (value mod 12), plus 12 when PM is set, so 12 AM equals hour 0 and 12 PM equals hour 12. This holds in BCD and in binary.
- R8: With `h24_mode` = 1, the hour byte is a plain 0..23 value and bit 7 has no PM meaning.
- R9: A strobe while `freeze` is 1 gives no pulse.
- R10: A strobe while `div_hold` is 1 gives no pulse.
- R11: A mismatch in any single non-wildcard field suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Update-ended strobe, one cycle per second |
| bin_mode | input | 1 | 1 = binary values, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| freeze | input | 1 | Time-setting freeze; blocks alarms |
| div_hold | input | 1 | Divider held in reset; blocks alarms |
| cur_sec | input | DW | Current seconds (post-increment) |
| cur_min | input | DW | Current minutes (post-increment) |
| cur_hr | input | DW | Current hours (post-increment) |
| alm_sec | input | DW | Alarm seconds or wildcard |
| alm_min | input | DW | Alarm minutes or wildcard |
| alm_hr | input | DW | Alarm hours or wildcard |
| alarm_pulse | output | 1 | One-cycle alarm indication |

## Verification
There is one register between the inputs and `alarm_pulse`. The result for a strobe is therefore due one clock after the edge that samples that strobe, and 0 again on the clock after that.

The bench changes its inputs one nanosecond after a rising edge. A behavioural model samples the same inputs on the next rising edge. The output is compared with the model at the falling edge that follows, every cycle.

Directed cases also check the pulse at that falling edge, and confirm that it has cleared one cycle later.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
   localparam int unsigned FIELD_CNT = 3;
   localparam int unsigned NIB_W     = 4;
   typedef enum int unsigned {FLD_SEC = 0, FLD_MIN = 1, FLD_HOUR = 2} fld_e;
endpackage

// File: rtl/rtc_alm_field_dec.sv
module rtc_alm_field_dec
   import rtc_alm_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter bit          IS_HOUR = 1'b0
) (
   input  logic [DW-1:0] raw,
   input  logic          bin_mode,
   input  logic          h24_mode,
   output logic [DW-1:0] value
);
   localparam logic [DW-1:0] TEN    = DW'(10);
   localparam logic [DW-1:0] TWELVE = DW'(12);

   logic          twelve_h;
   logic [DW-1:0] body;
   logic [DW-1:0] tens;
   logic [DW-1:0] units;
   logic [DW-1:0] plain;

   assign twelve_h = IS_HOUR && !h24_mode;

   always_comb begin
      body  = twelve_h ? {1'b0, raw[DW-2:0]} : raw;
      tens  = {{(DW-NIB_W){1'b0}}, body[2*NIB_W-1:NIB_W]};
      units = {{(DW-NIB_W){1'b0}}, body[NIB_W-1:0]};
      plain = bin_mode ? body : (tens * TEN + units);
      if (twelve_h)
         value = (plain % TWELVE) + (raw[DW-1] ? TWELVE : '0);
      else
         value = plain;
   end
endmodule

// File: rtl/rtc_alm_field_match.sv
module rtc_alm_field_match #(
   parameter int unsigned DW      = 8,
   parameter bit          IS_HOUR = 1'b0
) (
   input  logic [DW-1:0] cur_raw,
   input  logic [DW-1:0] alm_raw,
   input  logic          bin_mode,
   input  logic          h24_mode,
   output logic          hit
);
   logic [DW-1:0] cur_val;
   logic [DW-1:0] alm_val;
   logic          wild;

   rtc_alm_field_dec #(.DW(DW), .IS_HOUR(IS_HOUR)) i_cur_dec (
      .raw(cur_raw), .bin_mode(bin_mode), .h24_mode(h24_mode), .value(cur_val));

   rtc_alm_field_dec #(.DW(DW), .IS_HOUR(IS_HOUR)) i_alm_dec (
      .raw(alm_raw), .bin_mode(bin_mode), .h24_mode(h24_mode), .value(alm_val));

   assign wild = &alm_raw[DW-1:DW-2];
   assign hit  = wild || (cur_val == alm_val);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alm_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_stb,
   input  logic          bin_mode,
   input  logic          h24_mode,
   input  logic          freeze,
   input  logic          div_hold,
   input  logic [DW-1:0] cur_sec,
   input  logic [DW-1:0] cur_min,
   input  logic [DW-1:0] cur_hr,
   input  logic [DW-1:0] alm_sec,
   input  logic [DW-1:0] alm_min,
   input  logic [DW-1:0] alm_hr,
   output logic          alarm_pulse
);
   generate
      if (DW != 2 * NIB_W) begin : g_bad_dw
         $error("rtc_alarm_match: DW must be two BCD digits wide");
      end
   endgenerate

   logic [DW-1:0]        cur_arr [FIELD_CNT];
   logic [DW-1:0]        alm_arr [FIELD_CNT];
   logic [FIELD_CNT-1:0] field_hit;
   logic                 fire_d;
   logic                 pulse_q;

   assign cur_arr[FLD_SEC]  = cur_sec;
   assign cur_arr[FLD_MIN]  = cur_min;
   assign cur_arr[FLD_HOUR] = cur_hr;
   assign alm_arr[FLD_SEC]  = alm_sec;
   assign alm_arr[FLD_MIN]  = alm_min;
   assign alm_arr[FLD_HOUR] = alm_hr;

   generate
      for (genvar f = 0; f < FIELD_CNT; f++) begin : g_fld
         rtc_alm_field_match #(.DW(DW), .IS_HOUR(f == FLD_HOUR)) i_match (
            .cur_raw (cur_arr[f]),
            .alm_raw (alm_arr[f]),
            .bin_mode(bin_mode),
            .h24_mode(h24_mode),
            .hit     (field_hit[f]));
      end
   endgenerate

   assign fire_d = upd_stb && !freeze && !div_hold && (&field_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire_d;
   end

   assign alarm_pulse = pulse_q;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          upd_stb,
   input logic          freeze,
   input logic          div_hold,
   input logic [DW-1:0] alm_sec,
   input logic [DW-1:0] alm_min,
   input logic [DW-1:0] alm_hr,
   input logic          alarm_pulse
);
   // R2
   no_stb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> !alarm_pulse);
   // R9
   freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> !alarm_pulse);
   // R10
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_hold |=> !alarm_pulse);
   // R4
   all_wild_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !freeze && !div_hold && (&alm_sec[DW-1:DW-2]) &&
       (&alm_min[DW-1:DW-2]) && (&alm_hr[DW-1:DW-2])) |=> alarm_pulse);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.DW(DW)) i_chk (
   .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .freeze(freeze),
   .div_hold(div_hold), .alm_sec(alm_sec), .alm_min(alm_min),
   .alm_hr(alm_hr), .alarm_pulse(alarm_pulse));

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_stb = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
   logic       freeze = 1'b0, div_hold = 1'b0;
   logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
   logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
   logic       alarm_pulse;

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R1";
   logic  exp_q = 1'b0;

   always #2.5 clk = ~clk;

   rtc_alarm_match i_rtc_alarm_match (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .bin_mode(bin_mode),
      .h24_mode(h24_mode), .freeze(freeze), .div_hold(div_hold),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
      .alarm_pulse(alarm_pulse));

   function automatic int to_num(input int b, input bit hour, input bit bin, input bit h24);
      int v, s;
      s = (hour && !h24) ? (b % 128) : b;
      v = bin ? s : (s / 16) * 10 + (s % 16);
      if (hour && !h24) v = (v % 12) + ((b >= 128) ? 12 : 0);
      return v;
   endfunction

   function automatic bit fld_ok(input int c, input int a, input bit hour, input bit bin, input bit h24);
      if (a >= 192) return 1'b1;
      return to_num(c, hour, bin, h24) == to_num(a, hour, bin, h24);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) exp_q <= 1'b0;
      else exp_q <= upd_stb && !freeze && !div_hold &&
                    fld_ok(cur_sec, alm_sec, 0, bin_mode, h24_mode) &&
                    fld_ok(cur_min, alm_min, 0, bin_mode, h24_mode) &&
                    fld_ok(cur_hr,  alm_hr,  1, bin_mode, h24_mode);
   end

   always @(negedge clk) begin
      checks++;
      if (alarm_pulse !== exp_q) begin
         errors++;
         $display("FAIL %s (model): alarm_pulse=%0b expected=%0b", cur_tag, alarm_pulse, exp_q);
      end
   end

   task automatic check(input string req, input bit exp);
      checks++;
      if (alarm_pulse !== exp) begin
         errors++;
         $display("FAIL %s: alarm_pulse=%0b expected=%0b", req, alarm_pulse, exp);
      end
   endtask

   task automatic shot(input string req, input bit stb,
                       input logic [7:0] cs, cm, ch, as, am, ah,
                       input bit bin, input bit h24, input bit frz, input bit hold,
                       input bit exp);
      cur_tag = req;
      cur_sec = cs; cur_min = cm; cur_hr = ch;
      alm_sec = as; alm_min = am; alm_hr = ah;
      bin_mode = bin; h24_mode = h24; freeze = frz; div_hold = hold;
      upd_stb = stb;
      @(posedge clk); #1;
      upd_stb = 1'b0;
      @(negedge clk);
      check(req, exp);
      @(posedge clk); #1;
      @(negedge clk);
      check("R2", 1'b0);
      @(posedge clk); #1;
   endtask

   initial begin : watchdog
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      check("R1", 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      check("R1", 1'b0);
      @(posedge clk); #1;

      // R5 BCD match and mismatch
      shot("R5", 1, 8'h45, 8'h30, 8'h14, 8'h45, 8'h30, 8'h14, 0, 1, 0, 0, 1);
      shot("R11", 1, 8'h45, 8'h30, 8'h14, 8'h46, 8'h30, 8'h14, 0, 1, 0, 0, 0);
      shot("R11", 1, 8'h45, 8'h31, 8'h14, 8'h45, 8'h30, 8'h14, 0, 1, 0, 0, 0);
      shot("R11", 1, 8'h45, 8'h30, 8'h15, 8'h45, 8'h30, 8'h14, 0, 1, 0, 0, 0);
      // R6 binary
      shot("R6", 1, 8'h2D, 8'h1E, 8'h0E, 8'h2D, 8'h1E, 8'h0E, 1, 1, 0, 0, 1);
      shot("R6", 1, 8'h2D, 8'h1E, 8'h0E, 8'h45, 8'h1E, 8'h0E, 1, 1, 0, 0, 0);
      // R3 single-field wildcards
      shot("R3", 1, 8'h07, 8'h30, 8'h14, 8'hC0, 8'h30, 8'h14, 0, 1, 0, 0, 1);
      shot("R3", 1, 8'h07, 8'h59, 8'h14, 8'h00, 8'hFF, 8'h14, 0, 1, 0, 0, 0);
      shot("R3", 1, 8'h07, 8'h59, 8'h22, 8'h07, 8'hFF, 8'hC5, 0, 1, 0, 0, 1);
      // R4 all wildcards
      for (int k = 0; k < 4; k++)
         shot("R4", 1, 8'(k * 17), 8'(k * 9), 8'(k * 5), 8'hC0, 8'hFF, 8'hD3, k[0], k[1], 0, 0, 1);
      // R7 twelve-hour
      shot("R7", 1, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h92, 0, 0, 0, 0, 1);
      shot("R7", 1, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, 0, 0, 0, 0, 0);
      shot("R7", 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 0, 0, 0, 0, 1);
      shot("R7", 1, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h92, 0, 0, 0, 0, 0);
      shot("R7", 1, 8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h80, 1, 0, 0, 0, 1);
      shot("R7", 1, 8'h00, 8'h00, 8'h8B, 8'h00, 8'h00, 8'h0B, 1, 0, 0, 0, 0);
      // R8 twenty-four-hour
      shot("R8", 1, 8'h10, 8'h20, 8'h23, 8'h10, 8'h20, 8'h23, 0, 1, 0, 0, 1);
      shot("R8", 1, 8'h10, 8'h20, 8'h11, 8'h10, 8'h20, 8'h23, 0, 1, 0, 0, 0);
      shot("R8", 1, 8'h10, 8'h20, 8'h00, 8'h10, 8'h20, 8'h12, 0, 1, 0, 0, 0);
      // R9, R10 suppression, R2 without strobe
      shot("R9", 1, 8'h45, 8'h30, 8'h14, 8'h45, 8'h30, 8'h14, 0, 1, 1, 0, 0);
      shot("R10", 1, 8'h45, 8'h30, 8'h14, 8'h45, 8'h30, 8'h14, 0, 1, 0, 1, 0);
      shot("R2", 0, 8'h45, 8'h30, 8'h14, 8'h45, 8'h30, 8'h14, 0, 1, 0, 0, 0);
      shot("R5", 1, 8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23, 0, 1, 0, 0, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule